// File: doc/BRIEF.md
# Windowed Interrupt Routing Register File

This block holds the routing registers of an interrupt controller. Software reaches them through a two-offset window rather than direct addressing. It first writes a register number into an index register at bus offset 0x00. It then reads or writes the selected register through the data port at bus offset 0x10. Behind the window are four kinds of register: a writable identity word, a constant version word, an arbitration word that reads zero and ignores writes, and a routing table with two 32-bit words per interrupt pin.

The block decodes each pin's routing out of its table words and drives it as a constant output for a downstream delivery stage. Each pin gets an 8-bit vector, an 8-bit destination and a broadcast flag. Pin sampling, trigger modes, masking and delivery are left to other logic.

A small access state machine handles read timing. A read in state `ST_IDLE` that hits a valid offset moves the machine to `ST_RESP` (transition *accept*). In `ST_RESP` the registered read data is presented with a valid strobe. From there another accepted read keeps it in `ST_RESP` (transition *chain*), and anything else returns it to `ST_IDLE` (transition *drain*).

Top module: `ioredir_regs`

## Requirements
- R1: Only bus offsets 0x00 and 0x10 are decoded. A write to any other offset changes no register and no output. A read of any other offset raises no `bus_rvalid` and leaves `bus_rdata` at its previous value.
- R2: A write at offset 0x00 stores all 32 data bits as the index. A read at offset 0x00 returns the stored index.
- R3: Index 0 is a 32-bit identity register that reads back what was written through the data port.
- R4: Index 1 always reads 0x00170011 through the data port, and writes to it have no effect.
- R5: Index 2 reads 0 through the data port, and writes to it have no effect.
- R6: Pin p owns table index 0x10+2p (low word) and 0x10+2p+1 (high word). Both words read back the full value written to them. Indices 3 to 0x0F read 0 and discard writes.
- R7: A low-word write whose bits [7:0] are nonzero sets that pin's vector output to those bits on the next clock edge. A low-word write whose bits [7:0] are zero leaves the vector output unchanged, though the word itself is stored.
- R8: A pin's destination output equals bits [31:24] of its high word, updated on the edge after the write. The broadcast flag is 1 exactly when that byte is 0xFF.
- R9: A data-port read at an index of 0x10+2·NPIN or above returns 0xFFFFFFFF. A data-port write there changes no stored word and no output.
- R10: Each accepted read gives `bus_rvalid` high and the data in `bus_rdata` exactly one clock later. Back-to-back reads give back-to-back results in order.
- R11: A synchronous active-high reset clears the index, the identity word, all table words, all vector, destination and broadcast outputs, and `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle per accepted read |
| pin_vector | output | 8·NPIN | Vector of each pin, pin p at bits [8p+7:8p] |
| pin_dest | output | 8·NPIN | Destination of each pin, same packing |
| pin_bcast | output | NPIN | Broadcast flag of each pin |

## Verification
The bench builds the block with its default parameters: 24 pins, table base 0x10, index port at 0x00 and data port at 0x10. With those values the last table word (0x3F, high word of pin 23) and the first out-of-range index (0x40) are both reachable with ordinary index writes. That is where an off-by-one in the table limit or an aliasing wrap onto pin 0 would show. The bench also reaches both ends of the index space (0 and 0xFFFFFFFF), a reserved index, and a back-to-back read pair that exercises the *chain* transition.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;

    localparam logic [31:0] VERSION_WORD = 32'h0017_0011;
    localparam logic [31:0] MISS_WORD    = 32'hFFFF_FFFF;
    localparam logic [7:0]  DEST_ALL     = 8'hFF;

endpackage

// File: rtl/ioredir_access_fsm.sv
module ioredir_access_fsm
    import ioredir_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int OFF_INDEX = 'h00,
    parameter int OFF_DATA  = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              idx_we,
    output logic              data_we,
    output logic              rd_accept,
    output logic              rd_sel_data,
    output logic              rvalid
);

    localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(OFF_INDEX);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);

    acc_state_e state_q, state_d;
    logic       hit_index, hit_data;

    assign hit_index = (bus_addr == A_INDEX);
    assign hit_data  = (bus_addr == A_DATA);

    // Strobes to the register file; other offsets are dropped here (R1).
    assign idx_we      = bus_wr && hit_index;
    assign data_we     = bus_wr && hit_data;
    assign rd_accept   = bus_rd && (hit_index || hit_data);
    assign rd_sel_data = hit_data;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_accept ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: rvalid = 1'b0;
            ST_RESP: rvalid = 1'b1;
            default: rvalid = 1'b0;
        endcase
    end

endmodule

// File: rtl/ioredir_table.sv
module ioredir_table
    import ioredir_pkg::*;
#(
    parameter int NPIN  = 24,
    parameter int PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PIN_W-1:0]  wr_pin,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    input  logic [PIN_W-1:0]  rd_pin,
    input  logic              rd_hi,
    output logic [31:0]       rd_word,
    output logic [NPIN*8-1:0] pin_vector,
    output logic [NPIN*8-1:0] pin_dest,
    output logic [NPIN-1:0]   pin_bcast
);

    logic [31:0] lo_w [NPIN];
    logic [31:0] hi_w [NPIN];

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [31:0] lo_q, hi_q;
        logic [7:0]  vec_q;
        logic        sel;

        assign sel = we && (wr_pin == PIN_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q  <= '0;
                hi_q  <= '0;
                vec_q <= '0;
            end else if (sel) begin
                if (wr_hi) begin
                    hi_q <= wdata;
                end else begin
                    lo_q <= wdata;
                    // A zero vector byte keeps the previous vector (R7).
                    if (wdata[7:0] != 8'h00) vec_q <= wdata[7:0];
                end
            end
        end

        assign lo_w[p] = lo_q;
        assign hi_w[p] = hi_q;
        assign pin_vector[p*8 +: 8] = vec_q;
        assign pin_dest[p*8 +: 8]   = hi_q[31:24];
        assign pin_bcast[p]         = (hi_q[31:24] == DEST_ALL);
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_pin) < NPIN) rd_word = rd_hi ? hi_w[rd_pin] : lo_w[rd_pin];
    end

endmodule

// File: rtl/ioredir_regs.sv
module ioredir_regs
    import ioredir_pkg::*;
#(
    parameter int NPIN      = 24,
    parameter int ADDR_W    = 8,
    parameter int OFF_INDEX = 'h00,
    parameter int OFF_DATA  = 'h10,
    parameter int TBASE     = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [NPIN*8-1:0] pin_vector,
    output logic [NPIN*8-1:0] pin_dest,
    output logic [NPIN-1:0]   pin_bcast
);

    localparam int          PIN_W  = (NPIN > 1) ? $clog2(NPIN) : 1;
    localparam logic [31:0] TBASE_W = 32'(TBASE);
    localparam logic [31:0] TEND_W  = 32'(TBASE + 2 * NPIN);

    logic              idx_we, data_we, rd_accept, rd_sel_data;
    logic [31:0]       idx_q, id_q, arb_q, rdata_q;
    logic [PIN_W:0]    rel;
    logic              in_tbl, tbl_we;
    logic [31:0]       tbl_word, win_word, rd_word;

    ioredir_access_fsm #(
        .ADDR_W   (ADDR_W),
        .OFF_INDEX(OFF_INDEX),
        .OFF_DATA (OFF_DATA)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .idx_we     (idx_we),
        .data_we    (data_we),
        .rd_accept  (rd_accept),
        .rd_sel_data(rd_sel_data),
        .rvalid     (bus_rvalid)
    );

    // Table position of the current index.
    assign in_tbl = (idx_q >= TBASE_W) && (idx_q < TEND_W);
    assign rel    = (PIN_W + 1)'(idx_q - TBASE_W);
    assign tbl_we = data_we && in_tbl;

    ioredir_table #(
        .NPIN (NPIN),
        .PIN_W(PIN_W)
    ) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .we        (tbl_we),
        .wr_pin    (rel[PIN_W:1]),
        .wr_hi     (rel[0]),
        .wdata     (bus_wdata),
        .rd_pin    (rel[PIN_W:1]),
        .rd_hi     (rel[0]),
        .rd_word   (tbl_word),
        .pin_vector(pin_vector),
        .pin_dest  (pin_dest),
        .pin_bcast (pin_bcast)
    );

    // Index, identity and arbitration words; arbitration has no write path.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            id_q  <= '0;
            arb_q <= '0;
        end else begin
            if (idx_we) idx_q <= bus_wdata;
            if (data_we && idx_q == 32'd0) id_q <= bus_wdata;
        end
    end

    // Data-port view of the selected register.
    always_comb begin
        if (idx_q == 32'd0)       win_word = id_q;
        else if (idx_q == 32'd1)  win_word = VERSION_WORD;
        else if (idx_q == 32'd2)  win_word = arb_q;
        else if (in_tbl)          win_word = tbl_word;
        else if (idx_q >= TEND_W) win_word = MISS_WORD;
        else                      win_word = '0;
    end

    assign rd_word = rd_sel_data ? win_word : idx_q;

    always_ff @(posedge clk) begin
        if (rst)            rdata_q <= '0;
        else if (rd_accept) rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/ioredir_chk.sv
module ioredir_chk
    import ioredir_pkg::*;
#(
    parameter int NPIN      = 24,
    parameter int ADDR_W    = 8,
    parameter int OFF_INDEX = 'h00,
    parameter int OFF_DATA  = 'h10,
    parameter int TBASE     = 'h10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [31:0]       idx_q,
    input logic [NPIN*8-1:0] pin_vector,
    input logic [NPIN*8-1:0] pin_dest
);

    localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(OFF_INDEX);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);
    localparam logic [31:0]       TEND_W  = 32'(TBASE + 2 * NPIN);

    logic good_off;
    assign good_off = (bus_addr == A_INDEX) || (bus_addr == A_DATA);

    p_read_answered_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && good_off) |=> bus_rvalid);

    p_no_stray_valid_r1: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && good_off) |=> !bus_rvalid);

    p_bad_offset_inert_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !good_off) |=> ($stable(idx_q) && $stable(pin_vector) && $stable(pin_dest)));

    p_index_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == A_INDEX) |=> (bus_rdata == $past(idx_q)));

    p_version_const_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_DATA && idx_q == 32'd1) |=> (bus_rdata == VERSION_WORD));

    p_zero_vec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DATA && bus_wdata[7:0] == 8'h00) |=> $stable(pin_vector));

    p_miss_read_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_DATA && idx_q >= TEND_W) |=> (bus_rdata == MISS_WORD));

    p_miss_write_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DATA && idx_q >= TEND_W) |=> ($stable(pin_vector) && $stable(pin_dest)));

endmodule

bind ioredir_regs ioredir_chk #(
    .NPIN     (NPIN),
    .ADDR_W   (ADDR_W),
    .OFF_INDEX(OFF_INDEX),
    .OFF_DATA (OFF_DATA),
    .TBASE    (TBASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .idx_q     (idx_q),
    .pin_vector(pin_vector),
    .pin_dest  (pin_dest)
);

// File: tb/tb_ioredir_regs.sv
module tb_ioredir_regs;

    localparam int NPIN = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NPIN*8-1:0] pin_vector;
    logic [NPIN*8-1:0] pin_dest;
    logic [NPIN-1:0]   pin_bcast;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    ioredir_regs dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .pin_vector(pin_vector),
        .pin_dest  (pin_dest),
        .pin_bcast (pin_bcast)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a read result appears.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R1 unexpected rvalid actual=%08h expected=none", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic win_write(logic [31:0] idx, logic [31:0] d);
        bus_write(8'h00, idx);
        bus_write(8'h10, d);
    endtask

    function automatic logic [7:0] vec_of(int p);
        return pin_vector[p*8 +: 8];
    endfunction

    function automatic logic [7:0] dst_of(int p);
        return pin_dest[p*8 +: 8];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        check("R11 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
        check("R11 vectors after reset", {24'd0, vec_of(7)}, 32'd0);
        check("R11 bcast after reset", {8'd0, pin_bcast}, 32'd0);
        bus_read(8'h00, 32'd0, "R11 index after reset");
        bus_read(8'h10, 32'd0, "R11 identity after reset");

        // R2: index port
        bus_write(8'h00, 32'hCAFE_002A);
        bus_read(8'h00, 32'hCAFE_002A, "R2 index readback");

        // R3: identity
        win_write(32'd0, 32'hDEAD_BEEF);
        bus_read(8'h10, 32'hDEAD_BEEF, "R3 identity readback");

        // R4: version ignores writes
        win_write(32'd1, 32'h1234_5678);
        bus_read(8'h10, 32'h0017_0011, "R4 version word");

        // R5: arbitration ignores writes
        win_write(32'd2, 32'h0000_FFFF);
        bus_read(8'h10, 32'd0, "R5 arbitration word");

        // R6/R7: pin 5 low word at 0x1A
        win_write(32'h1A, 32'h0000_1234);
        check("R7 vector set", {24'd0, vec_of(5)}, 32'h34);
        bus_read(8'h10, 32'h0000_1234, "R6 low word readback");
        bus_write(8'h10, 32'h0000_AB00);
        check("R7 zero vector keeps output", {24'd0, vec_of(5)}, 32'h34);
        bus_read(8'h10, 32'h0000_AB00, "R6 low word stored with zero vector");

        // R8: pin 5 high word at 0x1B
        win_write(32'h1B, 32'h7700_0000);
        check("R8 dest value", {24'd0, dst_of(5)}, 32'h77);
        check("R8 no broadcast", {31'd0, pin_bcast[5]}, 32'd0);
        bus_write(8'h10, 32'hFF00_0000);
        check("R8 broadcast flag", {31'd0, pin_bcast[5]}, 32'd1);
        check("R8 broadcast dest", {24'd0, dst_of(5)}, 32'hFF);

        // R6/R8: last table word, pin 23 high at 0x3F
        win_write(32'h3F, 32'h4200_0000);
        check("R8 last pin dest", {24'd0, dst_of(23)}, 32'h42);
        bus_read(8'h10, 32'h4200_0000, "R6 last word readback");

        // R6: reserved index
        win_write(32'd5, 32'h0000_0055);
        bus_read(8'h10, 32'd0, "R6 reserved index reads zero");

        // R9: first index past the table
        win_write(32'h40, 32'h9900_0099);
        bus_read(8'h10, 32'hFFFF_FFFF, "R9 miss read");
        check("R9 no wrap onto pin 0 vector", {24'd0, vec_of(0)}, 32'd0);
        check("R9 no wrap onto pin 0 dest", {24'd0, dst_of(0)}, 32'd0);
        check("R9 last pin dest untouched", {24'd0, dst_of(23)}, 32'h42);
        win_write(32'hFFFF_FFFF, 32'h0000_0011);
        bus_read(8'h10, 32'hFFFF_FFFF, "R9 miss read at top index");

        // R1: bad offsets
        bus_write(8'h00, 32'h3F);
        bus_write(8'h08, 32'h0000_0011);
        bus_read(8'h00, 32'h3F, "R1 index unchanged by bad offset");
        bus_write(8'h14, 32'h1100_0000);
        check("R1 dest unchanged by bad offset", {24'd0, dst_of(23)}, 32'h42);
        bus_read(8'h04, 32'h0, "R1 placeholder");
        void'(exp_q.pop_back()); void'(tag_q.pop_back());
        @(negedge clk);
        check("R1 rdata held after bad read", bus_rdata, 32'h3F);

        // R10: back-to-back reads
        @(negedge clk);
        bus_addr = 8'h00; bus_rd = 1'b1;
        exp_q.push_back(32'h3F); tag_q.push_back("R10 first of pair");
        @(negedge clk);
        bus_addr = 8'h10;
        exp_q.push_back(32'h4200_0000); tag_q.push_back("R10 second of pair");
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        check("R10 rvalid drops after pair", {31'd0, bus_rvalid}, 32'd0);

        // R11: reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R11 dest cleared", {24'd0, dst_of(23)}, 32'd0);
        check("R11 vector cleared", {24'd0, vec_of(5)}, 32'd0);
        bus_read(8'h00, 32'd0, "R11 index cleared");

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(20 * 100000);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule